// File: doc/BRIEF.md
# Bidirectional Cascadable Scan Shift Latch

This block holds the row-select pattern of a display scan driver. A serial bit stream is clocked into a chain of `STAGES` (default 64) register stages. A latch stage copies that chain onto the parallel row outputs. A direction input chooses which end of the chain receives data. In forward mode, data enters at end A and leaves at end B. In reverse mode, data enters at end B and leaves at end A. The first bit written therefore reaches the far end after exactly `STAGES` rising clock edges. Several devices can be chained end to end, in either direction, to scan any number of rows.

Each serial end is split into an input, an output and an output enable, so that a tristate pad wrapper can sit outside the block. Only the end that currently acts as the output has its enable raised. An active-high clear input empties the register chain at once, without waiting for a clock edge. A synchronous active-low reset also empties the chain. The latch is level sensitive. While its hold input is low, the row outputs track the chain. While its hold input is high, they keep the last value they showed.

Top module: `scan_shift_latch`

## Requirements
- R1: When `rst_n` is low at a rising `clk` edge, every register stage becomes 0 at that edge and not before. The row outputs show this once the latch is transparent.
- R2: With `dir_fwd` = 1, each rising edge moves the chain one stage toward the highest row. `end_a_i` enters stage 1 (`row_q[0]`). `end_b_o` carries stage `STAGES`, so a bit presented on `end_a_i` appears on `end_b_o` after exactly `STAGES` rising edges.
- R3: With `dir_fwd` = 0, each rising edge moves the chain one stage toward the lowest row. `end_b_i` enters stage `STAGES` (`row_q[STAGES-1]`). `end_a_o` carries stage 1, so a bit presented on `end_b_i` appears on `end_a_o` after exactly `STAGES` rising edges.
- R4: `end_b_oe` = 1 and `end_a_oe` = 0 when `dir_fwd` = 1. The enables are reversed when `dir_fwd` = 0. Both follow `dir_fwd` combinationally, and an end whose enable is low drives 0 on its output.
- R5: A high level on `clr` sets every register stage to 0 at once, with no clock edge needed. While `clr` stays high, rising edges do not shift.
- R6: While `latch_hold` is 0, `row_q[k]` equals register stage k+1 for every k.
- R7: While `latch_hold` is 1, `row_q` keeps its value, whatever shifting, clear or reset happens to the register chain.
- R8: When two devices are joined, with the B end of the first wired to the A end of the second, a bit fed into the outer end reaches the opposite outer end after exactly 2×`STAGES` edges. This holds in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the chain moves on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the register chain |
| clr | input | 1 | Asynchronous active-high clear of the register chain |
| dir_fwd | input | 1 | 1 = forward (A to B), 0 = reverse (B to A) |
| latch_hold | input | 1 | 0 = latch transparent, 1 = latch holds |
| end_a_i | input | 1 | Serial input at end A (used in forward mode) |
| end_a_o | output | 1 | Serial output at end A (stage 1 in reverse mode) |
| end_a_oe | output | 1 | Output enable for end A |
| end_b_i | input | 1 | Serial input at end B (used in reverse mode) |
| end_b_o | output | 1 | Serial output at end B (stage STAGES in forward mode) |
| end_b_oe | output | 1 | Output enable for end B |
| row_q | output | STAGES | Latched parallel row outputs, bit k = stage k+1 |

## Verification
The serial outputs are due one rising edge after the input bit is presented, counted per stage, so the first bit reaches a single device's far end on edge `STAGES` and the far end of the pair on edge 2×`STAGES`. The bench drives inputs and samples outputs on falling edges and keeps a running count of edges, so the expected position of a pulse is computed from the edge count. The output enables and the asynchronous clear are due in the same half cycle as their stimulus, and are checked 1 ns after the input changes with no clock edge in between. The synchronous reset is checked both before its edge, when nothing may have changed yet, and after it.

// File: rtl/scan_pkg.sv
// Package: shared types for the scan shift latch.
// Assumes: single-bit direction encoding, 1 = forward, 0 = reverse.
package scan_pkg;

    typedef enum logic {
        SCAN_REV = 1'b0,
        SCAN_FWD = 1'b1
    } scan_dir_e;

endpackage

// File: rtl/scan_end_mux.sv
// Module: scan_end_mux
// Chooses which serial end feeds the chain and which end drives out.
// Assumes: purely combinational; the caller resolves the tristate pads.
module scan_end_mux
    import scan_pkg::*;
(
    input  scan_dir_e dir,
    input  logic      end_a_i,
    input  logic      end_b_i,
    input  logic      first_stage,
    input  logic      last_stage,
    output logic      serial_in,
    output logic      end_a_o,
    output logic      end_a_oe,
    output logic      end_b_o,
    output logic      end_b_oe
);

    // Route the serial input and enable the single output end.
    always_comb begin
        if (dir == SCAN_FWD) begin
            serial_in = end_a_i;
            end_b_oe  = 1'b1;
            end_a_oe  = 1'b0;
            end_b_o   = last_stage;
            end_a_o   = 1'b0;
        end else begin
            serial_in = end_b_i;
            end_a_oe  = 1'b1;
            end_b_oe  = 1'b0;
            end_a_o   = first_stage;
            end_b_o   = 1'b0;
        end
    end

endmodule

// File: rtl/scan_shift_chain.sv
// Module: scan_shift_chain
// Bidirectional serial register of STAGES bits; index 0 is stage 1.
// Assumes: clr is asynchronous and wins over rst_n and shifting.
module scan_shift_chain
    import scan_pkg::*;
#(
    parameter int STAGES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  scan_dir_e         dir,
    input  logic              serial_in,
    output logic [STAGES-1:0] stage_q
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] next_stage;

    // Compute the shifted image for the selected direction.
    always_comb begin
        if (dir == SCAN_FWD) begin
            next_stage = {stage_q[LAST-1:0], serial_in};
        end else begin
            next_stage = {serial_in, stage_q[LAST:1]};
        end
    end

    // Register the chain with asynchronous clear and synchronous reset.
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            stage_q <= '0;
        end else if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= next_stage;
        end
    end

endmodule

// File: rtl/scan_row_latch.sv
// Module: scan_row_latch
// Level-sensitive latch bank in front of the row outputs.
// Assumes: hold low = transparent; no reset, contents kept until opened.
module scan_row_latch #(
    parameter int STAGES = 64
) (
    input  logic              hold,
    input  logic [STAGES-1:0] d,
    output logic [STAGES-1:0] q
);

    // Pass the register image through while the latch is open.
    always_latch begin
        if (!hold) begin
            q = d;
        end
    end

endmodule

// File: rtl/scan_shift_latch.sv
// Module: scan_shift_latch (top)
// Cascadable bidirectional scan register with a transparent row latch.
// Assumes: pad tristating is done outside using the *_oe outputs.
module scan_shift_latch
    import scan_pkg::*;
#(
    parameter int STAGES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              dir_fwd,
    input  logic              latch_hold,
    input  logic              end_a_i,
    output logic              end_a_o,
    output logic              end_a_oe,
    input  logic              end_b_i,
    output logic              end_b_o,
    output logic              end_b_oe,
    output logic [STAGES-1:0] row_q
);

    scan_dir_e         dir;
    logic              serial_in;
    logic [STAGES-1:0] stage_q;

    assign dir = scan_dir_e'(dir_fwd);

    scan_end_mux end_mux_i (
        .dir         (dir),
        .end_a_i     (end_a_i),
        .end_b_i     (end_b_i),
        .first_stage (stage_q[0]),
        .last_stage  (stage_q[STAGES-1]),
        .serial_in   (serial_in),
        .end_a_o     (end_a_o),
        .end_a_oe    (end_a_oe),
        .end_b_o     (end_b_o),
        .end_b_oe    (end_b_oe)
    );

    scan_shift_chain #(.STAGES(STAGES)) chain_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .dir       (dir),
        .serial_in (serial_in),
        .stage_q   (stage_q)
    );

    scan_row_latch #(.STAGES(STAGES)) latch_i (
        .hold (latch_hold),
        .d    (stage_q),
        .q    (row_q)
    );

endmodule

// File: rtl/scan_shift_latch_chk.sv
// Module: scan_shift_latch_chk
// Property checker bound into scan_shift_latch.
// Assumes: inputs change away from the rising clock edge.
module scan_shift_latch_chk #(
    parameter int STAGES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              dir_fwd,
    input logic              latch_hold,
    input logic              end_a_i,
    input logic              end_b_i,
    input logic              end_a_oe,
    input logic              end_b_oe,
    input logic [STAGES-1:0] row_q,
    input logic [STAGES-1:0] stage_q
);

    AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (clr)
        (!rst_n) |=> (stage_q == '0)); // R1

    AST_FWD_STEP: assert property (@(posedge clk) disable iff (clr || !rst_n)
        (rst_n && dir_fwd) |=>
        (stage_q == {$past(stage_q[STAGES-2:0]), $past(end_a_i)})); // R2

    AST_REV_STEP: assert property (@(posedge clk) disable iff (clr || !rst_n)
        (rst_n && !dir_fwd) |=>
        (stage_q == {$past(end_b_i), $past(stage_q[STAGES-1:1])})); // R3

    AST_ONE_END_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({end_a_oe, end_b_oe})); // R4

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> (stage_q == '0)); // R5

    AST_LATCH_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_hold) |-> (row_q == stage_q)); // R6

    AST_LATCH_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_hold && $past(latch_hold)) |-> $stable(row_q)); // R7

endmodule

bind scan_shift_latch scan_shift_latch_chk #(.STAGES(STAGES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .dir_fwd    (dir_fwd),
    .latch_hold (latch_hold),
    .end_a_i    (end_a_i),
    .end_b_i    (end_b_i),
    .end_a_oe   (end_a_oe),
    .end_b_oe   (end_b_oe),
    .row_q      (row_q),
    .stage_q    (stage_q)
);

// File: tb/scan_shift_latch_tb_top.sv
// Bench: two cascaded devices checked against a 2*STAGES reference array.
module scan_shift_latch_tb_top;

    localparam int N   = 64;
    localparam int TOT = 2 * N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic dir_fwd = 1'b1;
    logic hold = 1'b0;
    logic head_in = 1'b0;
    logic tail_in = 1'b0;

    logic d0_a_o, d0_a_oe, d0_b_o, d0_b_oe;
    logic d1_a_o, d1_a_oe, d1_b_o, d1_b_oe;
    logic [N-1:0] d0_row, d1_row;
    logic link;

    logic [TOT-1:0] model;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // Resolve the shared pad between the two devices.
    assign link = d0_b_oe ? d0_b_o : (d1_a_oe ? d1_a_o : 1'b0);

    scan_shift_latch #(.STAGES(N)) dut_i (
        .clk (clk), .rst_n (rst_n), .clr (clr), .dir_fwd (dir_fwd),
        .latch_hold (hold),
        .end_a_i (head_in), .end_a_o (d0_a_o), .end_a_oe (d0_a_oe),
        .end_b_i (link), .end_b_o (d0_b_o), .end_b_oe (d0_b_oe),
        .row_q (d0_row)
    );

    scan_shift_latch #(.STAGES(N)) cascade_i (
        .clk (clk), .rst_n (rst_n), .clr (clr), .dir_fwd (dir_fwd),
        .latch_hold (hold),
        .end_a_i (link), .end_a_o (d1_a_o), .end_a_oe (d1_a_oe),
        .end_b_i (tail_in), .end_b_o (d1_b_o), .end_b_oe (d1_b_oe),
        .row_q (d1_row)
    );

    task automatic chk(input string req, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // One rising edge with a serial bit at the active outer end.
    task automatic shift(input logic b);
        if (dir_fwd) head_in = b; else tail_in = b;
        @(posedge clk);
        if (!clr && rst_n) begin
            if (dir_fwd) model = {model[TOT-2:0], b};
            else         model = {b, model[TOT-1:1]};
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model = '0;
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        finish_run();
    end

    initial begin
        model = '0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        // R1: reset state visible through the open latch
        chk("R1 reset rows", {d1_row, d0_row}, '0);
        rst_n = 1'b1;

        // R4: enables and idle outputs in both directions
        dir_fwd = 1'b1; #1;
        chk("R4 fwd enables", {d0_a_oe, d0_b_oe, d1_a_oe, d1_b_oe}, 4'b0101);
        chk("R4 fwd idle A out", d0_a_o, 1'b0);
        dir_fwd = 1'b0; #1;
        chk("R4 rev enables", {d0_a_oe, d0_b_oe, d1_a_oe, d1_b_oe}, 4'b1010);
        chk("R4 rev idle B out", d0_b_o, 1'b0);
        dir_fwd = 1'b1;
        @(negedge clk);

        // R2 / R8: single pulse forward, arrival edge computed from count
        do_reset();
        for (int n = 1; n <= TOT + 4; n++) begin
            shift(n == 1);
            chk($sformatf("R2 fwd pulse edge %0d", n), d0_b_o, (n == N));
            chk($sformatf("R8 fwd cascade edge %0d", n), d1_b_o, (n == TOT));
        end

        // R3 / R8: single pulse reverse
        dir_fwd = 1'b0;
        do_reset();
        for (int n = 1; n <= TOT + 4; n++) begin
            shift(n == 1);
            chk($sformatf("R3 rev pulse edge %0d", n), d1_a_o, (n == N));
            chk($sformatf("R8 rev cascade edge %0d", n), d0_a_o, (n == TOT));
        end

        // R2 / R6: patterned forward stream against the reference array
        dir_fwd = 1'b1;
        for (int k = 0; k < 3 * N; k++) begin
            shift(((k * 5 + 3) % 7) < 3);
            chk("R2 fwd serial out", d1_b_o, model[TOT-1]);
            chk("R6 rows follow", {d1_row, d0_row}, model);
        end

        // R3 / R6: patterned reverse stream continuing from that state
        dir_fwd = 1'b0;
        for (int k = 0; k < 3 * N; k++) begin
            shift(((k * 3 + 1) % 5) < 2);
            chk("R3 rev serial out", d0_a_o, model[0]);
            chk("R6 rows follow rev", {d1_row, d0_row}, model);
        end

        // R7: closed latch ignores shifting, clear and reset
        begin
            logic [TOT-1:0] snap;
            snap = {d1_row, d0_row};
            hold = 1'b1;
            for (int k = 0; k < 20; k++) shift(k[0]);
            chk("R7 hold over shifts", {d1_row, d0_row}, snap);
            clr = 1'b1; #1;
            chk("R7 hold over clear", {d1_row, d0_row}, snap);
            @(negedge clk);
            clr = 1'b0;
            model = '0;
            do_reset();
            chk("R7 hold over reset", {d1_row, d0_row}, snap);
            hold = 1'b0; #1;
            chk("R6 reopen shows chain", {d1_row, d0_row}, model);
        end

        // R5: asynchronous clear, no shifting while high
        dir_fwd = 1'b1;
        for (int k = 0; k < TOT; k++) shift(1'b1);
        chk("R5 filled", {d1_row, d0_row}, {TOT{1'b1}});
        clr = 1'b1; #1;
        chk("R5 clear without edge", {d1_row, d0_row}, '0);
        for (int k = 0; k < 3; k++) shift(1'b1);
        chk("R5 no shift while clear", {d1_row, d0_row}, '0);
        clr = 1'b0;
        model = '0;
        shift(1'b1);
        chk("R5 resumes after clear", {d1_row, d0_row}, model);

        // R1: synchronous reset acts only at the edge
        for (int k = 0; k < 10; k++) shift(1'b1);
        rst_n = 1'b0; #1;
        chk("R1 no change before edge", {d1_row, d0_row}, model);
        @(posedge clk);
        @(negedge clk);
        chk("R1 cleared at edge", {d1_row, d0_row}, '0);
        rst_n = 1'b1;
        model = '0;

        finish_run();
    end

endmodule